// File: doc/BRIEF.md
# Split-Section Binary Ripple Counter

This block is a four-bit binary counter split into two sections that run on their own. A one-bit section toggles on each falling transition of its own count input. A three-bit section advances on each falling transition of a second count input. Inside the three-bit section each bit toggles when the bit below it falls, in the manner of a ripple chain. Both sections are cleared together, but only when two clear inputs are high at the same time.

The count inputs are treated as slow, asynchronous levels. Each one passes through a synchronizer in the system clock domain and then through a falling-edge detector. The ripple behaviour is then modelled with synchronous logic, so every output comes straight from a register. A build-time source selector lets the upper section be driven from the lowest bit inside the block. In that build the block forms a modulo-16 counter with no external wiring.

Top module: `split_ripple_counter`

## Requirements
- R1: `count_o[0]` inverts once for each falling transition of `tick0_in` while the section is not being cleared.
- R2: `count_o[3:1]` increases by one, modulo 8, for each falling transition of the upper section's count source. Bit 1 toggles on every advance, and each higher bit toggles when the bit below it goes from 1 to 0.
- R3: When `clr_a` and `clr_b` are both high at a rising clock edge, `count_o` is all zeros after that edge. This clear wins over any count edge arriving in the same cycle.
- R4: When only one of `clr_a` and `clr_b` is high, both sections keep counting exactly as they do with both low.
- R5: Rising transitions of `tick0_in` and `tick1_in` leave `count_o` unchanged.
- R6: Each section wraps on its own. Bit 0 goes from 1 to 0, and bits 3:1 go from 7 to 0, without disturbing the other section.
- R7: `rst` high at a rising clock edge clears `count_o` to zero after that edge.
- R8: With `HI_SRC` set to chained, `tick1_in` is ignored and the upper section advances whenever bit 0 falls. `count_o` then steps through 0 to 15 and back to 0, one step per falling edge of `tick0_in`.
- R9: A falling transition on a count input that is presented before rising clock edge n shows on `count_o` after edge n+2 (SYNC_STAGES = 2), and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_a | input | 1 | First clear qualifier |
| clr_b | input | 1 | Second clear qualifier |
| tick0_in | input | 1 | Asynchronous count input for the one-bit section |
| tick1_in | input | 1 | Asynchronous count input for the upper section |
| count_o | output | HI_BITS+1 | Registered count; bit 0 comes from the one-bit section |

## Verification
The bench builds two copies of the block, both with the default three-bit upper section and a two-flop synchronizer. One copy uses an external source for the upper section and the other uses the chained source. Driving both copies from the same stimulus tests the independent sections and the full modulo-16 sequence in a single run, including every wrap point of each. With the default synchronizer depth, the exact clock latency of an edge can be pinned down. Each of the four combinations of the clear inputs is applied while edges keep arriving.

// File: rtl/src_pkg.sv
package src_pkg;
  // Selects what drives the upper section's advance
  typedef enum logic {
    SRC_EXTERNAL = 1'b0,
    SRC_CHAINED  = 1'b1
  } hi_src_e;
endpackage

// File: rtl/src_fall_det.sv
module src_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  // pipe[STAGES-1:0] synchronizes; pipe[STAGES] holds the previous synced value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/src_toggle_chain.sv
module src_toggle_chain #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe,
  input  logic             adv,
  output logic [WIDTH-1:0] q
);
  // Stage k toggles when all stages below it are about to fall from 1 to 0
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic bit_q;
    logic flip;
    if (k == 0) begin : g_first
      assign flip = adv;
    end else begin : g_rest
      assign flip = adv & (&q[k-1:0]);
    end
    always_ff @(posedge clk) begin
      if (rst || wipe) bit_q <= 1'b0;
      else if (flip)   bit_q <= ~bit_q;
    end
    assign q[k] = bit_q;
  end
endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter
  import src_pkg::*;
#(
  parameter int      SYNC_STAGES = 2,
  parameter int      HI_BITS     = 3,
  parameter hi_src_e HI_SRC      = SRC_EXTERNAL,
  localparam int     CNT_W       = HI_BITS + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_a,
  input  logic             clr_b,
  input  logic             tick0_in,
  input  logic             tick1_in,
  output logic [CNT_W-1:0] count_o
);
  localparam bit CHAINED = (HI_SRC == SRC_CHAINED);

  logic               wipe;
  logic               fall0;
  logic               fall1_ext;
  logic               adv_hi;
  logic [0:0]         lo_q;
  logic [HI_BITS-1:0] hi_q;

  assign wipe = clr_a & clr_b;

  src_fall_det #(.STAGES(SYNC_STAGES)) det0_i (
    .clk(clk), .rst(rst), .din(tick0_in), .fall(fall0)
  );

  src_fall_det #(.STAGES(SYNC_STAGES)) det1_i (
    .clk(clk), .rst(rst), .din(tick1_in), .fall(fall1_ext)
  );

  // Chained source: bit 0 falls exactly when it toggles while high
  assign adv_hi = CHAINED ? (fall0 & lo_q[0]) : fall1_ext;

  src_toggle_chain #(.WIDTH(1)) lo_i (
    .clk(clk), .rst(rst), .wipe(wipe), .adv(fall0), .q(lo_q)
  );

  src_toggle_chain #(.WIDTH(HI_BITS)) hi_i (
    .clk(clk), .rst(rst), .wipe(wipe), .adv(adv_hi), .q(hi_q)
  );

  assign count_o = {hi_q, lo_q};
endmodule

// File: rtl/src_counter_chk.sv
module src_counter_chk #(
  parameter int  HI_BITS = 3,
  localparam int CNT_W   = HI_BITS + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_a,
  input logic             clr_b,
  input logic             fire0,
  input logic             fire_hi,
  input logic [CNT_W-1:0] count
);
  typedef logic [HI_BITS-1:0] hi_t;

  p_lo_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    (fire0 && !(clr_a && clr_b)) |=> (count[0] != $past(count[0])));

  p_hi_step_r2: assert property (@(posedge clk) disable iff (rst)
    (fire_hi && !(clr_a && clr_b)) |=> (count[CNT_W-1:1] == hi_t'($past(count[CNT_W-1:1]) + 1'b1)));

  p_wipe_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_a && clr_b) |=> (count == '0));

  p_lo_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!fire0 && !(clr_a && clr_b)) |=> $stable(count[0]));

  p_hi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!fire_hi && !(clr_a && clr_b)) |=> $stable(count[CNT_W-1:1]));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (count == '0));
endmodule

bind split_ripple_counter src_counter_chk #(.HI_BITS(HI_BITS)) chk_i (
  .clk(clk), .rst(rst), .clr_a(clr_a), .clr_b(clr_b),
  .fire0(fall0), .fire_hi(adv_hi), .count(count_o)
);

// File: tb/split_ripple_counter_tb_top.sv
module split_ripple_counter_tb_top;
  import src_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr_a = 1'b0;
  logic       clr_b = 1'b0;
  logic       t0 = 1'b1;
  logic       t1 = 1'b1;
  logic [3:0] cnt_e;
  logic [3:0] cnt_c;

  int n_chk  = 0;
  int n_fail = 0;

  logic       m0 = 1'b0;
  logic [2:0] mh = 3'd0;
  logic [3:0] mc = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_ripple_counter #(.HI_SRC(SRC_EXTERNAL)) dut_i (
    .clk(clk), .rst(rst), .clr_a(clr_a), .clr_b(clr_b),
    .tick0_in(t0), .tick1_in(t1), .count_o(cnt_e)
  );

  split_ripple_counter #(.HI_SRC(SRC_CHAINED)) dut_c_i (
    .clk(clk), .rst(rst), .clr_a(clr_a), .clr_b(clr_b),
    .tick0_in(t0), .tick1_in(t1), .count_o(cnt_c)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic wiping();
    return clr_a && clr_b;
  endfunction

  // Falling edge on tick0, then release; checks latency, count and rise immunity
  task automatic pulse0(input string req);
    @(negedge clk) t0 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 lo not early", cnt_e, {mh, m0});
    chk("R9 chained not early", cnt_c, mc);
    @(negedge clk);
    if (!wiping()) begin
      m0 = ~m0;
      mc = mc + 4'd1;
    end
    chk(req, cnt_e, {mh, m0});
    chk("R8 chained sequence", cnt_c, mc);
    t0 = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 rise on tick0", cnt_e, {mh, m0});
  endtask

  task automatic pulse1(input string req);
    @(negedge clk) t1 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 hi not early", cnt_e, {mh, m0});
    @(negedge clk);
    if (!wiping()) mh = mh + 3'd1;
    chk(req, cnt_e, {mh, m0});
    chk("R8 tick1 ignored when chained", cnt_c, mc);
    t1 = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 rise on tick1", cnt_e, {mh, m0});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R7 reset state", cnt_e, 4'd0);
    chk("R7 reset state chained", cnt_c, 4'd0);
    repeat (4) @(negedge clk);
    chk("R5 release high after reset", cnt_e, 4'd0);

    // Low section alone, through its wrap (R1, R6)
    for (int i = 0; i < 5; i++) pulse0("R1 lo toggle / R6 lo wrap");
    // Upper section alone, past its wrap at 7 (R2, R6)
    for (int i = 0; i < 10; i++) pulse1("R2 hi step / R6 hi wrap");
    // Chained build through a full modulo-16 cycle and beyond (R8)
    for (int i = 0; i < 18; i++) pulse0("R1 lo toggle with chained R8");

    // All four clear combinations while edges arrive (R3, R4)
    for (int combo = 0; combo < 4; combo++) begin
      @(negedge clk);
      clr_a = combo[0];
      clr_b = combo[1];
      if (wiping()) begin
        m0 = 1'b0; mh = 3'd0; mc = 4'd0;
        @(negedge clk);
        chk("R3 both clears", cnt_e, 4'd0);
        chk("R3 both clears chained", cnt_c, 4'd0);
        pulse0("R3 clear beats tick0 edge");
        pulse1("R3 clear beats tick1 edge");
      end else begin
        pulse0("R4 single clear keeps lo counting");
        pulse1("R4 single clear keeps hi counting");
        pulse1("R4 single clear keeps hi counting");
      end
    end
    @(negedge clk);
    clr_a = 1'b0;
    clr_b = 1'b0;
    for (int i = 0; i < 3; i++) pulse1("R2 hi step after clear");
    pulse0("R1 lo toggle after clear");

    // Reset mid-count
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    m0 = 1'b0; mh = 3'd0; mc = 4'd0;
    chk("R7 reset mid count", cnt_e, 4'd0);
    chk("R7 reset mid count chained", cnt_c, 4'd0);
    repeat (4) @(negedge clk);
    pulse0("R1 lo toggle after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule